// File: doc/BRIEF.md
# Two-Wire Bus Recovery Sequencer

This block brings a wedged two-wire serial bus back to a usable state. A slave that lost track of a byte in the middle of a read can sit on the data line. The sequencer gets it out of that state by clocking the bus. On a start pulse it lets go of both open-drain lines. It then gives the clock line a fixed number of low-then-release pulses and samples the data line after every release. If the data line was high at least once, it forms a START and then a STOP on the data line. The clock line stays released for the whole of that step, so no listener ever sees a clock falling edge between the two conditions. Last, the bus is left idle for a bus-free interval and a done pulse is given.

The outputs are drive enables, where 1 pulls the line low. The pad inputs are brought in through a two-flop synchronizer. All timing is counted in microseconds from a tick, and a clock-per-microsecond prescaler parameter makes that tick.

A slave may stretch a released clock. The sequencer polls the clock line at a fixed step and gives up after a timeout. When it gives up it sets a stuck-low flag and carries on. The block reports four results:

- a failure flag when the data line was never seen high;
- a warning when either line is low just before the START;
- the stuck-low flag;
- a single-cycle done pulse.

The flags stay valid until the next start.

Top module: `twr_bus_recover`

## Requirements
- R1: On an accepted start, busy goes high and neither line is driven for the first SETUP_US microseconds.
- R2: Exactly NUM_PULSES (default 9) clock pulses are made. Each pulse drives the clock line low for SCL_LOW_US and then releases it.
- R3: After each clock release the synchronized data line is sampled into a sticky seen-high flag. Clocking always runs to the full pulse count, and a later low level does not clear the flag.
- R4: If the data line was never seen high, the run ends with the failure flag set, and the data line is never driven during that run.
- R5: If the data line was seen high, both lines are checked SETUP_US after the last pulse. If either reads low, the warning flag is set and the sequence goes on.
- R6: START (data line driven) and STOP (data line released) are made while the clock line is not driven. The data line rises no earlier than SETUP_US after the last clock release and stays driven for HOLD_US.
- R7: After the STOP, done is given BUF_US (default 60) microseconds later.
- R8: A released clock line is polled every POLL_US microseconds. If it stays low for SCL_TIMEOUT_US, the stuck-low flag is set and the pulse is counted as finished. A stretch shorter than the timeout does not set the flag.
- R9: A start pulse while busy is ignored. It neither restarts nor queues a run.
- R10: Done is high for exactly one cycle. The failure, warning and stuck-low flags hold their values after done and clear when the next start is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request a recovery run (ignored while busy) |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | Single-cycle pulse at the end of a run |
| fail_o | output | 1 | Data line never seen high in the last run |
| warn_o | output | 1 | A line was low at the pre-START check |
| stuck_o | output | 1 | The clock line was held low past the timeout |
| scl_drive_o | output | 1 | 1 pulls the clock line low |
| sda_drive_o | output | 1 | 1 pulls the data line low |
| scl_i | input | 1 | Clock line pad level |
| sda_i | input | 1 | Data line pad level |

## Verification
The bench models the open-drain bus with hold-low controls for each line and tries several patterns:

- a clean bus, where the data line is high throughout;
- a data line stuck low for the whole run, which is the only pattern that may end in failure;
- a data line released part-way through clocking;
- a data line high early and then held low, which separates a sticky flag from a last-sample flag;
- a data line pulled low only after the last sample, which can raise the warning alone;
- a short clock stretch, which must not raise the stuck-low flag;
- a clock line held low forever, which must raise both stuck-low and warning.

Edge timestamps taken from the drive outputs check the START/STOP setup, hold and bus-free spacing. A second start given in the middle of a run shows whether it was ignored.

// File: rtl/twr_pkg.sv
// Shared types for the two-wire bus recovery sequencer.
package twr_pkg;
    typedef enum logic [2:0] {
        TWR_IDLE,
        TWR_RELEASE,
        TWR_LOW,
        TWR_RISE,
        TWR_SETUP,
        TWR_START,
        TWR_FREE,
        TWR_DONE
    } twr_state_e;
endpackage

// File: rtl/twr_sync.sv
// Multi-stage synchronizer for asynchronous pad inputs.
// Assumes: inputs are level signals. Resets to all ones, the idle
// level of a pulled-up open-drain bus.
module twr_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            // Each stage registers the previous one (the first takes the pad).
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stage_q[g] <= '1;
                end else if (g == 0) begin
                    stage_q[g] <= d_i;
                end else begin
                    stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/twr_tick.sv
// Microsecond prescaler: pulses tick_o once every CLK_PER_US cycles.
// Assumes: CLK_PER_US >= 2. clr_i restarts the count so that a phase
// started with clr_i sees its first tick CLK_PER_US cycles later.
module twr_tick #(
    parameter int CLK_PER_US = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    output logic tick_o
);
    localparam int CW = $clog2(CLK_PER_US);

    logic [CW-1:0] cnt_q;

    assign tick_o = (cnt_q == CW'(CLK_PER_US - 1));

    // Count cycles, wrapping on a tick and restarting on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i || tick_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/twr_fsm.sv
// Recovery sequencer state machine.
// Assumes: scl_s_i/sda_s_i are already synchronized, and tick_i
// comes from a prescaler that restarts whenever phase_go_o is high.
// Drive outputs are decoded from the state register only.
module twr_fsm
    import twr_pkg::*;
#(
    parameter int NUM_PULSES     = 9,
    parameter int SCL_LOW_US     = 2,
    parameter int POLL_US        = 2,
    parameter int SCL_TIMEOUT_US = 1000,
    parameter int SETUP_US       = 1,
    parameter int HOLD_US        = 1,
    parameter int BUF_US         = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic tick_i,
    input  logic scl_s_i,
    input  logic sda_s_i,
    output logic phase_go_o,
    output logic busy_o,
    output logic done_o,
    output logic fail_o,
    output logic warn_o,
    output logic stuck_o,
    output logic scl_drive_o,
    output logic sda_drive_o
);
    localparam int MAX_A  = (SCL_TIMEOUT_US > BUF_US) ? SCL_TIMEOUT_US : BUF_US;
    localparam int MAX_US = (MAX_A > SCL_LOW_US) ? MAX_A : SCL_LOW_US;
    localparam int US_W   = $clog2(MAX_US + 2);
    localparam int PL_W   = $clog2(POLL_US + 1);
    localparam int PW     = $clog2(NUM_PULSES + 1);

    twr_state_e state_q, state_d;
    logic [US_W-1:0] us_q;
    logic [PL_W-1:0] poll_q;
    logic [PW-1:0]   pulse_q;
    logic seen_q, fail_q, warn_q, stuck_q;
    logic poll_hit, sample_ev, stuck_ev, last_pulse, seen_nx;

    assign poll_hit   = tick_i && (poll_q == PL_W'(POLL_US - 1));
    assign last_pulse = (pulse_q == PW'(NUM_PULSES - 1));
    assign seen_nx    = seen_q | sda_s_i;

    // Next-state decode and sample/timeout events.
    always_comb begin
        state_d   = state_q;
        sample_ev = 1'b0;
        stuck_ev  = 1'b0;
        case (state_q)
            TWR_IDLE:    if (start_i) state_d = TWR_RELEASE;
            TWR_RELEASE: if (tick_i && us_q == US_W'(SETUP_US - 1)) state_d = TWR_LOW;
            TWR_LOW:     if (tick_i && us_q == US_W'(SCL_LOW_US - 1)) state_d = TWR_RISE;
            TWR_RISE: begin
                if (poll_hit) begin
                    if (scl_s_i) begin
                        sample_ev = 1'b1;
                    end else if (us_q >= US_W'(SCL_TIMEOUT_US - 1)) begin
                        sample_ev = 1'b1;
                        stuck_ev  = 1'b1;
                    end
                end
                if (sample_ev) begin
                    if (!last_pulse)  state_d = TWR_LOW;
                    else if (seen_nx) state_d = TWR_SETUP;
                    else              state_d = TWR_DONE;
                end
            end
            TWR_SETUP:   if (tick_i && us_q == US_W'(SETUP_US - 1)) state_d = TWR_START;
            TWR_START:   if (tick_i && us_q == US_W'(HOLD_US - 1)) state_d = TWR_FREE;
            TWR_FREE:    if (tick_i && us_q == US_W'(BUF_US - 1)) state_d = TWR_DONE;
            TWR_DONE:    state_d = TWR_IDLE;
            default:     state_d = TWR_IDLE;
        endcase
    end

    assign phase_go_o = (state_d != state_q);

    // State, phase timers, pulse count and result flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TWR_IDLE;
            us_q    <= '0;
            poll_q  <= '0;
            pulse_q <= '0;
            seen_q  <= 1'b0;
            fail_q  <= 1'b0;
            warn_q  <= 1'b0;
            stuck_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (phase_go_o) begin
                us_q   <= '0;
                poll_q <= '0;
            end else if (tick_i) begin
                us_q   <= us_q + 1'b1;
                poll_q <= poll_hit ? '0 : poll_q + 1'b1;
            end
            if (state_q == TWR_IDLE && start_i) begin
                pulse_q <= '0;
                seen_q  <= 1'b0;
                fail_q  <= 1'b0;
                warn_q  <= 1'b0;
                stuck_q <= 1'b0;
            end
            if (sample_ev) begin
                seen_q  <= seen_nx;
                pulse_q <= pulse_q + 1'b1;
                if (last_pulse && !seen_nx) fail_q <= 1'b1;
            end
            if (stuck_ev) stuck_q <= 1'b1;
            if (state_q == TWR_SETUP && state_d == TWR_START)
                warn_q <= !(scl_s_i && sda_s_i);
        end
    end

    assign busy_o      = (state_q != TWR_IDLE);
    assign done_o      = (state_q == TWR_DONE);
    assign fail_o      = fail_q;
    assign warn_o      = warn_q;
    assign stuck_o     = stuck_q;
    assign scl_drive_o = (state_q == TWR_LOW);
    assign sda_drive_o = (state_q == TWR_START);

    AST_START_SCL_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        sda_drive_o |-> !scl_drive_o); // R6
    AST_START_NEEDS_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
        sda_drive_o |-> seen_q); // R4
    AST_FAIL_NO_SDA: assert property (@(posedge clk) disable iff (!rst_n)
        fail_q |-> !sda_drive_o); // R4
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R10
    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> ($stable(fail_o) && $stable(warn_o) && $stable(stuck_o))); // R10
    AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o && start_i) |=> busy_o); // R9
    AST_PULSE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (pulse_q <= PW'(NUM_PULSES))); // R2
endmodule

// File: rtl/twr_bus_recover.sv
// Top of the two-wire bus recovery sequencer.
// Assumes: external pull-ups on both lines; a drive output of 1 means
// the pad pulls that line low. Pad inputs are synchronized here.
module twr_bus_recover #(
    parameter int CLK_PER_US     = 50,
    parameter int NUM_PULSES     = 9,
    parameter int SCL_LOW_US     = 2,
    parameter int POLL_US        = 2,
    parameter int SCL_TIMEOUT_US = 1000,
    parameter int SETUP_US       = 1,
    parameter int HOLD_US        = 1,
    parameter int BUF_US         = 60,
    parameter int SYNC_STAGES    = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o,
    output logic done_o,
    output logic fail_o,
    output logic warn_o,
    output logic stuck_o,
    output logic scl_drive_o,
    output logic sda_drive_o,
    input  logic scl_i,
    input  logic sda_i
);
    logic [1:0] pads_s;
    logic       tick, phase_go;

    twr_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({scl_i, sda_i}),
        .q_o   (pads_s)
    );

    twr_tick #(.CLK_PER_US(CLK_PER_US)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (phase_go),
        .tick_o (tick)
    );

    twr_fsm #(
        .NUM_PULSES     (NUM_PULSES),
        .SCL_LOW_US     (SCL_LOW_US),
        .POLL_US        (POLL_US),
        .SCL_TIMEOUT_US (SCL_TIMEOUT_US),
        .SETUP_US       (SETUP_US),
        .HOLD_US        (HOLD_US),
        .BUF_US         (BUF_US)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .tick_i      (tick),
        .scl_s_i     (pads_s[1]),
        .sda_s_i     (pads_s[0]),
        .phase_go_o  (phase_go),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .fail_o      (fail_o),
        .warn_o      (warn_o),
        .stuck_o     (stuck_o),
        .scl_drive_o (scl_drive_o),
        .sda_drive_o (sda_drive_o)
    );
endmodule

// File: tb/sim_twr_bus_recover.sv
// Directed bench: open-drain bus model with per-line hold-low controls.
module sim_twr_bus_recover;
    localparam int CPU  = 10;
    localparam int TOUT = 20;
    localparam int BUF  = 60;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic scl_hold = 1'b0, sda_hold = 1'b0;
    logic busy, done, fail, warn, stuck, scl_d, sda_d;
    logic scl_pad, sda_pad;

    int checks = 0, failures = 0;
    int cyc = 0;
    logic mon_clr = 1'b0;
    int n_scl, n_sda, n_done;
    int t_scl_fall, t_sda_rise, t_sda_fall, t_done;
    logic viol, done_long, scl_p, sda_p, done_p;

    always #10 clk = ~clk;  // 50 MHz

    assign scl_pad = ~scl_d & ~scl_hold;
    assign sda_pad = ~sda_d & ~sda_hold;

    twr_bus_recover #(.CLK_PER_US(CPU), .SCL_TIMEOUT_US(TOUT), .BUF_US(BUF)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start),
        .busy_o(busy), .done_o(done), .fail_o(fail), .warn_o(warn), .stuck_o(stuck),
        .scl_drive_o(scl_d), .sda_drive_o(sda_d),
        .scl_i(scl_pad), .sda_i(sda_pad)
    );

    // Edge monitor on the drive outputs.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mon_clr) begin
            n_scl <= 0; n_sda <= 0; n_done <= 0;
            t_scl_fall <= 0; t_sda_rise <= 0; t_sda_fall <= 0; t_done <= 0;
            viol <= 1'b0; done_long <= 1'b0;
        end else begin
            if (scl_d && !scl_p) n_scl <= n_scl + 1;
            if (!scl_d && scl_p) t_scl_fall <= cyc;
            if (sda_d && !sda_p) begin n_sda <= n_sda + 1; t_sda_rise <= cyc; end
            if (!sda_d && sda_p) t_sda_fall <= cyc;
            if (done) begin n_done <= n_done + 1; t_done <= cyc; end
            if (done && done_p) done_long <= 1'b1;
            if (scl_d && sda_d) viol <= 1'b1;
        end
        scl_p <= scl_d; sda_p <= sda_d; done_p <= done;
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic clear_mon();
        @(negedge clk); mon_clr = 1'b1;
        @(negedge clk); mon_clr = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_done();
        bit seen = 1'b0;
        for (int k = 0; k < 20000 && !seen; k++) begin
            @(negedge clk);
            if (n_done > 0) seen = 1'b1;
        end
        chk(seen, "R7", "done reached", int'(seen), 1);
    endtask

    task automatic wait_scl_rel(input int n);
        for (int k = 0; k < 20000 && !(n_scl >= n && !scl_d); k++) @(negedge clk);
    endtask

    task automatic t_reset();
        chk(!busy && !done && !scl_d && !sda_d, "R1", "reset idle", {busy, done, scl_d, sda_d}, 0);
        chk(!fail && !warn && !stuck, "R10", "reset flags", {fail, warn, stuck}, 0);
    endtask

    task automatic t_clean();
        clear_mon();
        pulse_start();
        repeat (2) @(negedge clk);
        chk(busy && !scl_d && !sda_d, "R1", "released at start", {busy, scl_d, sda_d}, 4);
        repeat (100) @(negedge clk);
        pulse_start();                            // R9: must be ignored
        wait_done();
        chk(n_scl == 9, "R2", "pulse count", n_scl, 9);
        chk(n_sda == 1, "R6", "one START", n_sda, 1);
        chk(!viol, "R6", "SCL driven during START", int'(viol), 0);
        chk(t_sda_rise - t_scl_fall >= CPU, "R6", "START setup cycles", t_sda_rise - t_scl_fall, CPU);
        chk(t_sda_fall - t_sda_rise >= CPU, "R6", "START hold cycles", t_sda_fall - t_sda_rise, CPU);
        chk(t_done - t_sda_fall >= BUF*CPU && t_done - t_sda_fall <= BUF*CPU+2,
            "R7", "bus free cycles", t_done - t_sda_fall, BUF*CPU);
        chk(!fail && !warn && !stuck, "R3", "clean flags", {fail, warn, stuck}, 0);
        chk(!done_long, "R10", "done width", int'(done_long), 0);
        repeat (30) @(negedge clk);
        chk(!busy && n_done == 1, "R9", "second start ignored", n_done, 1);
    endtask

    task automatic t_sda_stuck();
        sda_hold = 1'b1;
        clear_mon();
        pulse_start();
        wait_done();
        chk(fail, "R4", "fail set", int'(fail), 1);
        chk(n_sda == 0, "R4", "no START issued", n_sda, 0);
        chk(n_scl == 9, "R2", "pulses with SDA low", n_scl, 9);
        repeat (50) @(negedge clk);
        chk(fail, "R10", "fail holds after done", int'(fail), 1);
        sda_hold = 1'b0;
    endtask

    task automatic t_late_release();
        sda_hold = 1'b1;
        clear_mon();
        pulse_start();
        repeat (2) @(negedge clk);
        chk(!fail, "R10", "fail cleared by start", int'(fail), 0);
        wait_scl_rel(6);
        sda_hold = 1'b0;
        wait_done();
        chk(!fail && n_sda == 1, "R3", "late high recovers", n_sda, 1);
        chk(n_scl == 9, "R3", "full clocking", n_scl, 9);
    endtask

    task automatic t_sticky();
        clear_mon();
        pulse_start();
        wait_scl_rel(2);
        repeat (25) @(negedge clk);
        sda_hold = 1'b1;
        wait_done();
        chk(!fail, "R3", "seen flag sticky", int'(fail), 0);
        chk(n_scl == 9, "R3", "clocking continues", n_scl, 9);
        chk(warn, "R5", "warn with SDA low", int'(warn), 1);
        chk(n_sda == 1, "R5", "START after warn", n_sda, 1);
        sda_hold = 1'b0;
    endtask

    task automatic t_warn_only();
        clear_mon();
        pulse_start();
        wait_scl_rel(9);
        repeat (25) @(negedge clk);
        sda_hold = 1'b1;
        wait_done();
        chk(warn && !fail, "R5", "warn only after last sample", {warn, fail}, 2);
        sda_hold = 1'b0;
    endtask

    task automatic t_stretch();
        clear_mon();
        pulse_start();
        for (int k = 0; k < 20000 && !scl_d; k++) @(negedge clk);
        for (int k = 0; k < 20000 && scl_d; k++) @(negedge clk);
        scl_hold = 1'b1;
        repeat (50) @(negedge clk);
        scl_hold = 1'b0;
        wait_done();
        chk(!stuck, "R8", "short stretch no stuck", int'(stuck), 0);
        chk(n_scl == 9 && !warn, "R8", "stretch pulses", n_scl, 9);
    endtask

    task automatic t_scl_stuck();
        scl_hold = 1'b1;
        clear_mon();
        pulse_start();
        wait_done();
        chk(stuck, "R8", "stuck flag", int'(stuck), 1);
        chk(warn && !fail, "R5", "warn with SCL low", {warn, fail}, 2);
        chk(n_scl == 9, "R8", "pulses after timeouts", n_scl, 9);
        scl_hold = 1'b0;
        repeat (10) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_clean();
        t_sda_stuck();
        t_late_release();
        t_sticky();
        t_warn_only();
        t_stretch();
        t_scl_stuck();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule